// File: doc/BRIEF.md
# Cylinder-Head-Sector Command Decoder and Sector Sequencer

This block takes the addressing bytes of a disk command, splits them into drive, head, sector, cylinder and block count, and checks the result against the geometry configured for the selected drive. From the checked values it forms a linear sector number, ((cylinder × heads) + head) × sectors + sector, in a two-stage registered multiply. A `done` strobe marks the cycle in which the address and the error flags are valid.

During a multi-sector transfer the data path pulses `step` once per sector. The sequencer then moves to the next sector in track order. The sector wraps into the head and the head wraps into the cylinder. At the last cylinder the position stops and does not wrap. Each drive has its own geometry register, loaded through a parameter-specify port. An optional reserved-cylinder mode adds one to every decoded cylinder, except for vendor opcodes, which always address cylinder 0.

Top module: `chs_sequencer`

## Requirements
- R1: Decode fields from `cmd_bytes` (byte k at bits 8k+7:8k): drive = byte1[7:5], head = byte1[4:0], sector = byte2[5:0], cylinder = {byte2[7:6], byte3}, count = byte4. They appear on the `cur_*` outputs and on `xfer_count` when `done` is high.
- R2: When `cyl_offset_en` is 1, the decoded cylinder is the field value plus 1. When `cyl_offset_en` is 1 and byte0 (the opcode) is 0xF0 or above, the cylinder is 0. When `cyl_offset_en` is 0, the field value is used unchanged.
- R3: A head at or above the drive's head count, or a sector at or above its sectors per track, sets `addr_err`. `err_code` then reads 0x21, and this takes precedence over every other code.
- R4: A decoded cylinder at or above the drive's cylinder count sets `seek_err` and makes `cur_cyl` equal to the last cylinder (count − 1). With `addr_err` clear, `err_code` reads 0x15. With no error, `err_code` reads 0x00.
- R5: On `done`, `lin_addr` equals ((cur_cyl × heads) + cur_head) × sectors + cur_sector, using the current (possibly clamped) position.
- R6: An accepted command or step raises `busy` for two cycles. `done` then pulses high for exactly one cycle, two cycles after `busy` rises. `cmd_valid` and `step` are ignored while `busy` is high.
- R7: A step increments the sector. At sectors-per-track the sector becomes 0 and the head increments. At the head count the head becomes 0 and the cylinder increments. A step clears `seek_err` and rechecks head and sector for `addr_err`.
- R8: A step that would carry past the last cylinder leaves `cur_cyl` at the last cylinder, with head and sector at 0.
- R9: Each step decrements `xfer_count`. The count stays at 0 once it reaches 0.
- R10: A `cfg_we` pulse writes cylinders, heads and sectors for drive `cfg_drive` when `cfg_drive` < NUM_DRIVES, and is ignored otherwise. After reset every drive holds 306 cylinders, 4 heads and 17 sectors. A drive number at or above NUM_DRIVES has all-zero geometry, so any command to it reports `addr_err`.
- R11: When `cmd_valid` and `step` arrive in the same cycle, the command is taken and the step is dropped. A geometry write that arrives in the cycle a command is accepted does not affect that command, which uses the geometry held before the write. The geometry captured at acceptance governs all later steps.
- R12: After reset, `busy`, `done`, `lin_addr`, every `cur_*` output, `xfer_count`, both error flags and `err_code` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyl_offset_en | input | 1 | Reserved-cylinder mode |
| cfg_we | input | 1 | Geometry write strobe |
| cfg_drive | input | 3 | Drive whose geometry is written |
| cfg_cyls | input | 10 | Cylinder count to write |
| cfg_heads | input | 5 | Head count to write |
| cfg_spt | input | 6 | Sectors per track to write |
| cmd_valid | input | 1 | Command bytes present |
| cmd_bytes | input | 40 | Command bytes 0 to 4 |
| step | input | 1 | Advance to the next sector |
| busy | output | 1 | Address computation in progress |
| done | output | 1 | One-cycle strobe: outputs valid |
| lin_addr | output | 21 | Linear sector number |
| cur_drive | output | 3 | Selected drive |
| cur_head | output | 5 | Current head |
| cur_sector | output | 6 | Current sector |
| cur_cyl | output | 10 | Current cylinder |
| xfer_count | output | 8 | Remaining block count |
| addr_err | output | 1 | Illegal head or sector |
| seek_err | output | 1 | Cylinder out of range |
| err_code | output | 8 | 0x21, 0x15 or 0x00 |

## Verification
Two pairs of events can land in the same cycle. The first pair is a new command and a sector step. The bench raises `cmd_valid` and `step` together and expects the decoded command position, with the sector not advanced. The second pair is a geometry write and the acceptance of a command for that same drive. The bench writes a smaller head count in the accept cycle and expects no error and an address built on the old head count. It then sends the same command again and expects an illegal-address error.

// File: rtl/chs_pkg.sv
package chs_pkg;
  localparam int DRV_W  = 3;
  localparam int HEAD_W = 5;
  localparam int SEC_W  = 6;
  localparam int CYL_W  = 10;
  localparam int CNT_W  = 8;
  localparam int BYTE_W = 8;
  localparam int CMD_BYTES = 5;
  localparam int PART_W = CYL_W + HEAD_W;
  localparam int LIN_W  = PART_W + SEC_W;

  localparam logic [BYTE_W-1:0] OPC_VENDOR_MIN   = 8'hF0;
  localparam logic [BYTE_W-1:0] ERR_CODE_NONE    = 8'h00;
  localparam logic [BYTE_W-1:0] ERR_CODE_ILLEGAL = 8'h21;
  localparam logic [BYTE_W-1:0] ERR_CODE_SEEK    = 8'h15;

  typedef struct packed {
    logic [CYL_W-1:0]  cyls;
    logic [HEAD_W-1:0] heads;
    logic [SEC_W-1:0]  spt;
  } geom_t;

  typedef struct packed {
    logic [DRV_W-1:0]  drive;
    logic [HEAD_W-1:0] head;
    logic [SEC_W-1:0]  sector;
    logic [CYL_W-1:0]  cyl;
    logic [CNT_W-1:0]  count;
  } chs_t;

  // Highest valid cylinder; an unconfigured drive (zero cylinders) pins to 0.
  function automatic logic [CYL_W-1:0] last_cyl(input logic [CYL_W-1:0] cyls);
    return (cyls == '0) ? '0 : cyls - {{(CYL_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic out_of_range(input chs_t p, input geom_t g);
    return (p.head >= g.heads) || (p.sector >= g.spt);
  endfunction
endpackage

// File: rtl/chs_decode.sv
module chs_decode
  import chs_pkg::*;
(
  input  logic [CMD_BYTES*BYTE_W-1:0] cmd_bytes,
  input  logic                        offset_en,
  input  geom_t                       geom,
  output chs_t                        chs,
  output logic                        addr_bad,
  output logic                        seek_bad
);
  logic [BYTE_W-1:0] opc, b1, b2, b3, b4;
  logic [CYL_W:0]    cyl_ext;
  logic              vendor_op;

  assign opc = cmd_bytes[0*BYTE_W +: BYTE_W];
  assign b1  = cmd_bytes[1*BYTE_W +: BYTE_W];
  assign b2  = cmd_bytes[2*BYTE_W +: BYTE_W];
  assign b3  = cmd_bytes[3*BYTE_W +: BYTE_W];
  assign b4  = cmd_bytes[4*BYTE_W +: BYTE_W];

  always_comb begin
    vendor_op = offset_en && (opc >= OPC_VENDOR_MIN);
    if (vendor_op)
      cyl_ext = '0;
    else
      cyl_ext = {1'b0, b2[7:6], b3} + {{CYL_W{1'b0}}, offset_en};
    seek_bad   = cyl_ext >= {1'b0, geom.cyls};
    chs.drive  = b1[7:5];
    chs.head   = b1[4:0];
    chs.sector = b2[5:0];
    chs.cyl    = seek_bad ? last_cyl(geom.cyls) : cyl_ext[CYL_W-1:0];
    chs.count  = b4;
    addr_bad   = out_of_range(chs, geom);
  end
endmodule

// File: rtl/chs_stepper.sv
module chs_stepper
  import chs_pkg::*;
(
  input  chs_t  cur,
  input  geom_t geom,
  output chs_t  nxt,
  output logic  addr_bad
);
  logic [SEC_W:0]  sec_inc;
  logic [HEAD_W:0] head_inc;
  logic [CYL_W:0]  cyl_inc;

  always_comb begin
    sec_inc  = {1'b0, cur.sector} + {{SEC_W{1'b0}}, 1'b1};
    head_inc = {1'b0, cur.head} + {{HEAD_W{1'b0}}, 1'b1};
    cyl_inc  = {1'b0, cur.cyl} + {{CYL_W{1'b0}}, 1'b1};
    nxt = cur;
    if (sec_inc >= {1'b0, geom.spt}) begin
      nxt.sector = '0;
      if (head_inc >= {1'b0, geom.heads}) begin
        nxt.head = '0;
        if (cyl_inc >= {1'b0, geom.cyls})
          nxt.cyl = last_cyl(geom.cyls);
        else
          nxt.cyl = cyl_inc[CYL_W-1:0];
      end else begin
        nxt.head = head_inc[HEAD_W-1:0];
      end
    end else begin
      nxt.sector = sec_inc[SEC_W-1:0];
    end
    nxt.count = (cur.count == '0) ? '0 : cur.count - {{(CNT_W-1){1'b0}}, 1'b1};
    addr_bad  = out_of_range(nxt, geom);
  end
endmodule

// File: rtl/chs_addr_pipe.sv
module chs_addr_pipe
  import chs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  chs_t             pos,
  input  geom_t            geom,
  output logic [LIN_W-1:0] lin,
  output logic             done,
  output logic             stage_busy
);
  logic [PART_W-1:0] part_q;
  logic              mid_q;
  logic              done_q;
  logic [LIN_W-1:0]  lin_q;

  function automatic logic [PART_W-1:0] track_index(
    input logic [CYL_W-1:0] c, input logic [HEAD_W-1:0] nh, input logic [HEAD_W-1:0] h);
    return PART_W'(c) * PART_W'(nh) + PART_W'(h);
  endfunction

  function automatic logic [LIN_W-1:0] sector_index(
    input logic [PART_W-1:0] t, input logic [SEC_W-1:0] ns, input logic [SEC_W-1:0] s);
    return LIN_W'(t) * LIN_W'(ns) + LIN_W'(s);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      part_q <= '0;
      mid_q  <= 1'b0;
      done_q <= 1'b0;
      lin_q  <= '0;
    end else begin
      mid_q  <= start;
      done_q <= mid_q;
      if (start) part_q <= track_index(pos.cyl, geom.heads, pos.head);
      if (mid_q) lin_q  <= sector_index(part_q, geom.spt, pos.sector);
    end
  end

  assign lin        = lin_q;
  assign done       = done_q;
  assign stage_busy = mid_q;
endmodule

// File: rtl/chs_geom_bank.sv
module chs_geom_bank
  import chs_pkg::*;
#(
  parameter int NUM_DRIVES = 2,
  parameter int DEF_CYLS   = 306,
  parameter int DEF_HEADS  = 4,
  parameter int DEF_SPT    = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DRV_W-1:0] wr_drive,
  input  geom_t            wr_geom,
  input  logic [DRV_W-1:0] rd_drive,
  output geom_t            rd_geom
);
  localparam geom_t GEOM_RESET = '{cyls:  CYL_W'(DEF_CYLS),
                                   heads: HEAD_W'(DEF_HEADS),
                                   spt:   SEC_W'(DEF_SPT)};
  geom_t regs [NUM_DRIVES];

  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drive
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[d] <= GEOM_RESET;
      else if (wr_en && (wr_drive == DRV_W'(d)))
        regs[d] <= wr_geom;
    end
  end

  always_comb begin
    rd_geom = '0;
    for (int d = 0; d < NUM_DRIVES; d++)
      if (rd_drive == DRV_W'(d)) rd_geom = regs[d];
  end
endmodule

// File: rtl/chs_sequencer.sv
module chs_sequencer
  import chs_pkg::*;
#(
  parameter int NUM_DRIVES = 2,
  parameter int DEF_CYLS   = 306,
  parameter int DEF_HEADS  = 4,
  parameter int DEF_SPT    = 17
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cyl_offset_en,
  input  logic                        cfg_we,
  input  logic [DRV_W-1:0]            cfg_drive,
  input  logic [CYL_W-1:0]            cfg_cyls,
  input  logic [HEAD_W-1:0]           cfg_heads,
  input  logic [SEC_W-1:0]            cfg_spt,
  input  logic                        cmd_valid,
  input  logic [CMD_BYTES*BYTE_W-1:0] cmd_bytes,
  input  logic                        step,
  output logic                        busy,
  output logic                        done,
  output logic [LIN_W-1:0]            lin_addr,
  output logic [DRV_W-1:0]            cur_drive,
  output logic [HEAD_W-1:0]           cur_head,
  output logic [SEC_W-1:0]            cur_sector,
  output logic [CYL_W-1:0]            cur_cyl,
  output logic [CNT_W-1:0]            xfer_count,
  output logic                        addr_err,
  output logic                        seek_err,
  output logic [BYTE_W-1:0]           err_code
);
  // Named events for the checker.
  logic  cmd_go, step_go, go_q, pipe_busy;
  geom_t sel_geom, act, cfg_geom;
  chs_t  cur, dec_chs, step_chs;
  logic  dec_addr_bad, dec_seek_bad, step_addr_bad;
  logic  addr_err_q, seek_err_q;

  assign cfg_geom = '{cyls: cfg_cyls, heads: cfg_heads, spt: cfg_spt};
  assign cmd_go   = cmd_valid && !busy;
  assign step_go  = step && !busy && !cmd_valid;
  assign busy     = go_q || pipe_busy;

  chs_geom_bank #(
    .NUM_DRIVES(NUM_DRIVES), .DEF_CYLS(DEF_CYLS),
    .DEF_HEADS(DEF_HEADS), .DEF_SPT(DEF_SPT)
  ) i_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_drive(cfg_drive),
    .wr_geom(cfg_geom), .rd_drive(cmd_bytes[BYTE_W+5 +: DRV_W]),
    .rd_geom(sel_geom)
  );

  chs_decode i_dec (
    .cmd_bytes(cmd_bytes), .offset_en(cyl_offset_en), .geom(sel_geom),
    .chs(dec_chs), .addr_bad(dec_addr_bad), .seek_bad(dec_seek_bad)
  );

  chs_stepper i_step (
    .cur(cur), .geom(act), .nxt(step_chs), .addr_bad(step_addr_bad)
  );

  chs_addr_pipe i_pipe (
    .clk(clk), .rst_n(rst_n), .start(go_q), .pos(cur), .geom(act),
    .lin(lin_addr), .done(done), .stage_busy(pipe_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      go_q       <= 1'b0;
      cur        <= '0;
      act        <= '0;
      addr_err_q <= 1'b0;
      seek_err_q <= 1'b0;
    end else begin
      go_q <= cmd_go || step_go;
      if (cmd_go) begin
        cur        <= dec_chs;
        act        <= sel_geom;
        addr_err_q <= dec_addr_bad;
        seek_err_q <= dec_seek_bad;
      end else if (step_go) begin
        cur        <= step_chs;
        addr_err_q <= step_addr_bad;
        seek_err_q <= 1'b0;
      end
    end
  end

  always_comb begin
    if (addr_err_q)      err_code = ERR_CODE_ILLEGAL;
    else if (seek_err_q) err_code = ERR_CODE_SEEK;
    else                 err_code = ERR_CODE_NONE;
  end

  assign cur_drive  = cur.drive;
  assign cur_head   = cur.head;
  assign cur_sector = cur.sector;
  assign cur_cyl    = cur.cyl;
  assign xfer_count = cur.count;
  assign addr_err   = addr_err_q;
  assign seek_err   = seek_err_q;
endmodule

// File: rtl/chs_sequencer_chk.sv
module chs_sequencer_chk
  import chs_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              step_go,
  input logic [LIN_W-1:0]  lin_addr,
  input logic [HEAD_W-1:0] cur_head,
  input logic [SEC_W-1:0]  cur_sector,
  input logic [CYL_W-1:0]  cur_cyl,
  input logic [CNT_W-1:0]  xfer_count,
  input logic              addr_err,
  input geom_t             act
);
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> ##1 done);

  p_hold_while_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(cur_cyl) && $stable(cur_head) && $stable(cur_sector)));

  p_legal_when_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !addr_err) |-> (cur_head < act.heads && cur_sector < act.spt));

  p_cyl_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && act.cyls != '0) |-> (cur_cyl < act.cyls));

  p_count_dec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_go && xfer_count != '0) |=> (xfer_count == $past(xfer_count) - 8'd1));

  p_linear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lin_addr == LIN_W'(cur_cyl) * LIN_W'(act.heads) * LIN_W'(act.spt)
                          + LIN_W'(cur_head) * LIN_W'(act.spt) + LIN_W'(cur_sector)));
endmodule

bind chs_sequencer chs_sequencer_chk i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .step_go(step_go),
  .lin_addr(lin_addr), .cur_head(cur_head), .cur_sector(cur_sector),
  .cur_cyl(cur_cyl), .xfer_count(xfer_count), .addr_err(addr_err), .act(act)
);

// File: tb/test_chs_sequencer.sv
`timescale 1ns/1ps
module test_chs_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyl_offset_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_drive = '0;
  logic [9:0]  cfg_cyls = '0;
  logic [4:0]  cfg_heads = '0;
  logic [5:0]  cfg_spt = '0;
  logic        cmd_valid = 1'b0;
  logic [39:0] cmd_bytes = '0;
  logic        step = 1'b0;
  logic        busy, done, addr_err, seek_err;
  logic [20:0] lin_addr;
  logic [2:0]  cur_drive;
  logic [4:0]  cur_head;
  logic [5:0]  cur_sector;
  logic [9:0]  cur_cyl;
  logic [7:0]  xfer_count, err_code;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  chs_sequencer i_chs_sequencer (
    .clk(clk), .rst_n(rst_n), .cyl_offset_en(cyl_offset_en), .cfg_we(cfg_we),
    .cfg_drive(cfg_drive), .cfg_cyls(cfg_cyls), .cfg_heads(cfg_heads),
    .cfg_spt(cfg_spt), .cmd_valid(cmd_valid), .cmd_bytes(cmd_bytes), .step(step),
    .busy(busy), .done(done), .lin_addr(lin_addr), .cur_drive(cur_drive),
    .cur_head(cur_head), .cur_sector(cur_sector), .cur_cyl(cur_cyl),
    .xfer_count(xfer_count), .addr_err(addr_err), .seek_err(seek_err),
    .err_code(err_code)
  );

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input int act_v, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
    end
  endtask

  function automatic int exp_lin(input int c, input int h, input int s, input int nh, input int ns);
    return c * nh * ns + h * ns + s;
  endfunction

  function automatic logic [39:0] pack(input int opc, input int d, input int h,
                                       input int s, input int c, input int n);
    logic [7:0] b1, b2, b3;
    b1 = {d[2:0], h[4:0]};
    b2 = {c[9:8], s[5:0]};
    b3 = c[7:0];
    return {n[7:0], b3, b2, b1, opc[7:0]};
  endfunction

  // Called at a negedge; returns at the negedge where done must be high.
  task automatic send(input int opc, input int d, input int h, input int s, input int c, input int n);
    cmd_bytes = pack(opc, d, h, s, c, n);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_step();
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic cfg(input int d, input int c, input int h, input int s);
    cfg_we = 1'b1; cfg_drive = d[2:0]; cfg_cyls = c[9:0]; cfg_heads = h[4:0]; cfg_spt = s[5:0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic expect_pos(input string tag, input int c, input int h, input int s,
                            input int nh, input int ns, input int code);
    chk(done == 1'b1, {tag, " done"}, done, 1);
    chk(cur_cyl == c[9:0], {tag, " cyl"}, cur_cyl, c);
    chk(cur_head == h[4:0], {tag, " head"}, cur_head, h);
    chk(cur_sector == s[5:0], {tag, " sector"}, cur_sector, s);
    chk(err_code == code[7:0], {tag, " err_code"}, err_code, code);
    if (code != 8'h21)
      chk(lin_addr == exp_lin(c, h, s, nh, ns), {tag, " lin"}, lin_addr, exp_lin(c, h, s, nh, ns));
  endtask

  task automatic t_reset();
    chk(busy == 0 && done == 0, "R12 busy/done", {busy, done}, 0);
    chk(lin_addr == 0 && cur_cyl == 0 && cur_head == 0 && cur_sector == 0, "R12 position", lin_addr, 0);
    chk(xfer_count == 0 && cur_drive == 0, "R12 count/drive", xfer_count, 0);
    chk(err_code == 0 && !addr_err && !seek_err, "R12 errors", err_code, 0);
  endtask

  task automatic t_decode();
    send(8'h08, 1, 3, 5, 291, 7);
    expect_pos("R1 R5 decode", 291, 3, 5, 4, 17, 0);
    chk(cur_drive == 3'd1, "R1 drive", cur_drive, 1);
    chk(xfer_count == 8'd7, "R1 count", xfer_count, 7);
    send(8'h08, 0, 0, 0, 0, 0);
    expect_pos("R1 R5 zero", 0, 0, 0, 4, 17, 0);
  endtask

  task automatic t_offset();
    cyl_offset_en = 1'b1;
    send(8'h08, 0, 1, 2, 10, 1);
    expect_pos("R2 offset added", 11, 1, 2, 4, 17, 0);
    send(8'hF8, 0, 1, 2, 10, 1);
    expect_pos("R2 vendor forces 0", 0, 1, 2, 4, 17, 0);
    send(8'hEF, 0, 1, 2, 10, 1);
    expect_pos("R2 below vendor", 11, 1, 2, 4, 17, 0);
    send(8'h08, 0, 0, 0, 305, 1);
    expect_pos("R2 R4 offset past end", 305, 0, 0, 4, 17, 8'h15);
    cyl_offset_en = 1'b0;
    send(8'hF8, 0, 1, 2, 10, 1);
    expect_pos("R2 no offset mode", 10, 1, 2, 4, 17, 0);
  endtask

  task automatic t_illegal();
    send(8'h08, 0, 4, 0, 5, 1);
    chk(addr_err == 1'b1 && err_code == 8'h21, "R3 head at limit", err_code, 8'h21);
    send(8'h08, 0, 0, 17, 5, 1);
    chk(addr_err == 1'b1 && err_code == 8'h21, "R3 sector at limit", err_code, 8'h21);
    send(8'h08, 0, 3, 16, 5, 1);
    expect_pos("R3 max legal", 5, 3, 16, 4, 17, 0);
    send(8'h08, 0, 4, 0, 400, 1);
    chk(err_code == 8'h21 && seek_err == 1'b1, "R3 R4 precedence", err_code, 8'h21);
    chk(cur_cyl == 10'd305, "R4 clamp with illegal", cur_cyl, 305);
  endtask

  task automatic t_seek();
    send(8'h08, 0, 0, 0, 400, 1);
    expect_pos("R4 seek clamp", 305, 0, 0, 4, 17, 8'h15);
    chk(seek_err == 1'b1 && addr_err == 1'b0, "R4 flags", seek_err, 1);
    send(8'h08, 0, 0, 0, 306, 1);
    expect_pos("R4 at count", 305, 0, 0, 4, 17, 8'h15);
  endtask

  task automatic t_step();
    send(8'h08, 0, 3, 16, 10, 5);
    do_step();
    expect_pos("R7 full carry", 11, 0, 0, 4, 17, 0);
    chk(xfer_count == 8'd4, "R9 decrement", xfer_count, 4);
    do_step();
    expect_pos("R7 sector inc", 11, 0, 1, 4, 17, 0);
    send(8'h08, 0, 1, 16, 10, 5);
    do_step();
    expect_pos("R7 head carry", 10, 2, 0, 4, 17, 0);
    send(8'h08, 0, 0, 0, 400, 5);
    do_step();
    chk(seek_err == 1'b0 && err_code == 8'h15 - 8'h15, "R7 step clears seek", seek_err, 0);
  endtask

  task automatic t_saturate();
    send(8'h08, 0, 3, 16, 305, 5);
    do_step();
    expect_pos("R8 hold last cyl", 305, 0, 0, 4, 17, 0);
    do_step();
    expect_pos("R8 continue on last", 305, 0, 1, 4, 17, 0);
  endtask

  task automatic t_count();
    send(8'h08, 0, 0, 0, 1, 1);
    do_step();
    chk(xfer_count == 8'd0, "R9 to zero", xfer_count, 0);
    do_step();
    chk(xfer_count == 8'd0, "R9 floor", xfer_count, 0);
  endtask

  task automatic t_busy();
    cmd_bytes = pack(8'h08, 0, 2, 3, 20, 9);
    cmd_valid = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R6 busy raised", busy, 1);
    cmd_bytes = pack(8'h08, 1, 1, 1, 50, 2);
    step = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    step = 1'b0;
    @(negedge clk);
    expect_pos("R6 ignore while busy", 20, 2, 3, 4, 17, 0);
    chk(busy == 1'b0, "R6 busy dropped", busy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R6 single pulse", done, 0);
    chk(cur_cyl == 10'd20 && xfer_count == 8'd9, "R6 position kept", cur_cyl, 20);
  endtask

  task automatic t_collide();
    cmd_bytes = pack(8'h08, 0, 1, 4, 30, 3);
    cmd_valid = 1'b1;
    step = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    step = 1'b0;
    @(negedge clk);
    @(negedge clk);
    expect_pos("R11 command beats step", 30, 1, 4, 4, 17, 0);
    chk(xfer_count == 8'd3, "R11 count not stepped", xfer_count, 3);
    cfg_we = 1'b1; cfg_drive = 3'd0; cfg_cyls = 10'd306; cfg_heads = 5'd2; cfg_spt = 6'd17;
    cmd_bytes = pack(8'h08, 0, 3, 0, 7, 1);
    cmd_valid = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    cmd_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    expect_pos("R11 old geometry used", 7, 3, 0, 4, 17, 0);
    send(8'h08, 0, 3, 0, 7, 1);
    chk(err_code == 8'h21, "R11 new geometry next", err_code, 8'h21);
    cfg(0, 306, 4, 17);
  endtask

  task automatic t_specify();
    cfg(0, 612, 8, 26);
    send(8'h08, 0, 7, 25, 600, 1);
    expect_pos("R10 new geometry", 600, 7, 25, 8, 26, 0);
    send(8'h08, 1, 7, 0, 0, 1);
    chk(err_code == 8'h21, "R10 other drive untouched", err_code, 8'h21);
    cfg(6, 612, 8, 26);
    send(8'h08, 6, 0, 0, 0, 1);
    chk(addr_err == 1'b1 && err_code == 8'h21, "R10 absent drive", err_code, 8'h21);
    chk(cur_drive == 3'd6, "R10 drive field", cur_drive, 6);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_offset();
    t_illegal();
    t_seek();
    t_step();
    t_saturate();
    t_count();
    t_busy();
    t_collide();
    t_specify();
    summary();
  end
endmodule